// File: doc/BRIEF.md
# Linear Photodiode Array Scan Driver

This block produces the timing for a self-scanning linear photodiode array: a start pulse and the two non-overlapping shift-register clock phases that step the array's internal address from one photodiode to the next. All intervals are counted in cycles of the system clock. The clock frequency is a parameter, and the minimum intervals in nanoseconds and microseconds are derived from it. One photodiode is read per cycle of the second phase.

Configuration inputs give the array length code, the high time of each phase, the idle gap between phases and the requested start-to-start interval. That interval is the charge integration time of the photodiodes. All four values are captured only in the cycle a scan begins. If the requested interval is shorter than the scan itself, it is stretched to the scan length and a sticky flag is raised. A scan request starts one scan. If the continuous input is still high when the interval runs out, the next scan starts in that same cycle. A separate command drives a global-clear pulse on the saturation control gate while the driver is idle.

Top module: `lpa_scan_driver`

## Requirements
- R1: `phi1` and `phi2` are never high in the same cycle.
- R2: Each high pulse of `phi1` and `phi2` lasts exactly H cycles. H is the larger of `cfg_high` and MIN_HI, and MIN_HI is 200 ns expressed in clock cycles (10 at 50 MHz).
- R3: Between the fall of `phi2` and the next rise of `phi1`, both phases stay low for exactly `cfg_gap` cycles. A gap of 0 makes the phases complementary.
- R4: `phi_st` rises together with the first `phi2` pulse of a scan and stays high for H+1 cycles. It therefore overlaps `phi2` for H cycles, and exactly one fall of `phi2` occurs while `phi_st` is high.
- R5: `cfg_pix_code` values 0, 1, 2 and 3 give 128, 256, 512 and 1024 `phi2` pulses per scan.
- R6: `busy` stays high for T cycles from the start of a scan. T is the larger of `cfg_integ` and N·2·(H+`cfg_gap`), and a restarted scan begins exactly T cycles after the previous one.
- R7: `integ_clamped` is set when a scan starts with `cfg_integ` below the scan length. It remains set until `rst_n` is asserted. An interval equal to the scan length does not set it.
- R8: Configuration changes made while a scan is running do not alter that scan.
- R9: If `scan_cont` is high when an interval ends, a new scan starts in the same cycle. Otherwise `busy` falls and no further scan starts.
- R10: An `arst_req` accepted while idle drives `sat_gate` high for ARST_CYC cycles. ARST_CYC defaults to 5 µs plus one cycle, which is 251 cycles at 50 MHz.
- R11: `arst_req` has no effect while `busy` is high, and `scan_req` has no effect while `sat_gate` is high. When both requests arrive in the same idle cycle, the scan wins.
- R12: While in reset and right after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pix_code | input | 2 | Array length code (128 << code pixels) |
| cfg_high | input | HW | Requested phase high time in cycles |
| cfg_gap | input | HW | Gap between phases in cycles |
| cfg_integ | input | IW | Requested start-to-start interval in cycles |
| scan_req | input | 1 | Start a scan when idle |
| scan_cont | input | 1 | Keep restarting scans at each interval end |
| arst_req | input | 1 | Start a global-clear pulse when idle |
| phi1 | output | 1 | First shift-register clock phase |
| phi2 | output | 1 | Second shift-register clock phase (one pixel per pulse) |
| phi_st | output | 1 | Start pulse |
| sat_gate | output | 1 | Saturation control gate level (high clears all photodiodes) |
| busy | output | 1 | High for the whole integration interval |
| integ_clamped | output | 1 | Sticky flag for a stretched interval |

## Verification
The bound assertions check the following on every cycle: the phases never overlap, every phase pulse meets the 200 ns floor, the start pulse overlaps `phi2` long enough and rises only with it, clock phases appear only inside `busy`, `busy` drops only at an interval end, the clamp flag stays set, and the clear pulse exceeds 5 µs and never coexists with `busy`. Several properties can only be shown by the bench's scenarios, because they depend on the programmed values:
- the exact pulse widths, gaps and pixel counts for each array length;
- the stretched and unstretched intervals;
- isolation from configuration writes made mid-scan;
- the spacing of continuous restarts;
- the ignored requests.

// File: rtl/lpa_scan_pkg.sv
package lpa_scan_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TWO,
    PH_GAP2,
    PH_ONE,
    PH_GAP1
  } phase_e;

  // Number of photodiodes selected by the 2-bit length code.
  function automatic int unsigned pixels_of(input logic [1:0] code);
    return 32'd128 << code;
  endfunction

  // Phase high time after applying the minimum-width floor.
  function automatic int unsigned eff_hold(input int unsigned raw, input int unsigned floor_v);
    return (raw < floor_v) ? floor_v : raw;
  endfunction

  // Cycles occupied by one complete scan: each pixel slot holds both phases and both gaps.
  function automatic int unsigned scan_span(input int unsigned npix, input int unsigned hold,
                                            input int unsigned gap);
    return npix * 2 * (hold + gap);
  endfunction

endpackage

// File: rtl/lpa_cfg_latch.sv
module lpa_cfg_latch
  import lpa_scan_pkg::*;
#(
  parameter int HW = 8,
  parameter int IW = 24,
  parameter int NW = 11,
  parameter int unsigned MIN_HI = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    cfg_pix_code,
  input  logic [HW-1:0] cfg_high,
  input  logic [HW-1:0] cfg_gap,
  input  logic [IW-1:0] cfg_integ,
  output logic [HW-1:0] hold_q,
  output logic [HW-1:0] gap_q,
  output logic [NW-1:0] npix_q,
  output logic [IW-1:0] intv_q,
  output logic          clamp_err
);

  logic [31:0] n_w, h_w, g_w, span_w, req_w, iv_w;
  logic        short_req;

  always_comb begin
    n_w       = pixels_of(cfg_pix_code);
    h_w       = eff_hold(32'(cfg_high), MIN_HI);
    g_w       = 32'(cfg_gap);
    span_w    = scan_span(n_w, h_w, g_w);
    req_w     = 32'(cfg_integ);
    short_req = req_w < span_w;
    iv_w      = short_req ? span_w : req_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= HW'(MIN_HI);
      gap_q     <= '0;
      npix_q    <= NW'(128);
      intv_q    <= '1;
      clamp_err <= 1'b0;
    end else if (load) begin
      hold_q    <= HW'(h_w);
      gap_q     <= cfg_gap;
      npix_q    <= NW'(n_w);
      intv_q    <= IW'(iv_w);
      clamp_err <= clamp_err | short_req;
    end
  end

endmodule

// File: rtl/lpa_phase_seq.sv
module lpa_phase_seq
  import lpa_scan_pkg::*;
#(
  parameter int HW = 8,
  parameter int NW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [HW-1:0] hold,
  input  logic [HW-1:0] gap,
  input  logic [NW-1:0] npix,
  output logic          phi1,
  output logic          phi2,
  output logic          phi_st,
  output logic          running
);

  phase_e        st, nxt;
  logic [HW-1:0] cnt;
  logic [HW-1:0] seg_len;
  logic [NW-1:0] slot;
  logic          seg_last;
  logic          last_slot;
  logic          slot_adv;
  logic          stail;

  always_comb begin
    seg_len   = (st == PH_TWO || st == PH_ONE) ? hold : gap;
    seg_last  = (cnt == seg_len - HW'(1));
    last_slot = (slot == npix - NW'(1));
    unique case (st)
      PH_TWO:  nxt = (gap != '0) ? PH_GAP2 : PH_ONE;
      PH_GAP2: nxt = PH_ONE;
      PH_ONE:  nxt = (gap != '0) ? PH_GAP1 : (last_slot ? PH_IDLE : PH_TWO);
      PH_GAP1: nxt = last_slot ? PH_IDLE : PH_TWO;
      default: nxt = PH_IDLE;
    endcase
    slot_adv = seg_last && ((st == PH_ONE && gap == '0) || st == PH_GAP1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PH_IDLE;
      cnt   <= '0;
      slot  <= '0;
      stail <= 1'b0;
    end else if (start) begin
      st    <= PH_TWO;
      cnt   <= '0;
      slot  <= '0;
      stail <= 1'b0;
    end else begin
      stail <= (st == PH_TWO) && seg_last && (slot == '0);
      if (st != PH_IDLE) begin
        if (seg_last) begin
          cnt <= '0;
          st  <= nxt;
          if (slot_adv) slot <= slot + NW'(1);
        end else begin
          cnt <= cnt + HW'(1);
        end
      end
    end
  end

  assign phi2    = (st == PH_TWO);
  assign phi1    = (st == PH_ONE);
  assign phi_st  = ((st == PH_TWO) && (slot == '0)) || stail;
  assign running = (st != PH_IDLE);

endmodule

// File: rtl/lpa_allreset_timer.sv
module lpa_allreset_timer #(
  parameter int unsigned ARST_CYC = 251
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic gate
);

  localparam int AW = $clog2(ARST_CYC + 1);

  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate <= 1'b0;
      cnt  <= '0;
    end else if (!gate) begin
      if (fire) begin
        gate <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == AW'(ARST_CYC - 1)) begin
      gate <= 1'b0;
    end else begin
      cnt <= cnt + AW'(1);
    end
  end

endmodule

// File: rtl/lpa_scan_driver.sv
module lpa_scan_driver #(
  parameter int unsigned CLK_MHZ  = 50,
  parameter int          HW       = 8,
  parameter int          IW       = 24,
  parameter int unsigned MIN_HI   = (CLK_MHZ * 200 + 999) / 1000,
  parameter int unsigned ARST_CYC = CLK_MHZ * 5 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_pix_code,
  input  logic [HW-1:0] cfg_high,
  input  logic [HW-1:0] cfg_gap,
  input  logic [IW-1:0] cfg_integ,
  input  logic          scan_req,
  input  logic          scan_cont,
  input  logic          arst_req,
  output logic          phi1,
  output logic          phi2,
  output logic          phi_st,
  output logic          sat_gate,
  output logic          busy,
  output logic          integ_clamped
);

  localparam int NW = 11;

  logic [HW-1:0] hold_q, gap_q;
  logic [NW-1:0] npix_q;
  logic [IW-1:0] intv_q;
  logic [IW-1:0] icnt;
  logic          scan_go, restart, load, intv_end, arst_fire, running;

  // Named internal events, visible to the bound checker.
  assign scan_go   = scan_req && !busy && !sat_gate;
  assign intv_end  = busy && (icnt == intv_q - IW'(1));
  assign restart   = intv_end && scan_cont;
  assign load      = scan_go || restart;
  assign arst_fire = arst_req && !busy && !sat_gate && !scan_req;

  lpa_cfg_latch #(.HW(HW), .IW(IW), .NW(NW), .MIN_HI(MIN_HI)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .cfg_pix_code (cfg_pix_code),
    .cfg_high     (cfg_high),
    .cfg_gap      (cfg_gap),
    .cfg_integ    (cfg_integ),
    .hold_q       (hold_q),
    .gap_q        (gap_q),
    .npix_q       (npix_q),
    .intv_q       (intv_q),
    .clamp_err    (integ_clamped)
  );

  lpa_phase_seq #(.HW(HW), .NW(NW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (load),
    .hold    (hold_q),
    .gap     (gap_q),
    .npix    (npix_q),
    .phi1    (phi1),
    .phi2    (phi2),
    .phi_st  (phi_st),
    .running (running)
  );

  lpa_allreset_timer #(.ARST_CYC(ARST_CYC)) u_arst (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (arst_fire),
    .gate  (sat_gate)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      icnt <= '0;
    end else if (load) begin
      busy <= 1'b1;
      icnt <= '0;
    end else if (intv_end) begin
      busy <= 1'b0;
    end else if (busy) begin
      icnt <= icnt + IW'(1);
    end
  end

endmodule

// File: rtl/lpa_scan_checker.sv
module lpa_scan_checker #(
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned MIN_HI  = 10
) (
  input logic clk,
  input logic rst_n,
  input logic phi1,
  input logic phi2,
  input logic phi_st,
  input logic sat_gate,
  input logic busy,
  input logic integ_clamped,
  input logic intv_end
);

  localparam int unsigned ARST_MIN = CLK_MHZ * 5;

  logic [15:0] run1, run2, ov_run, sat_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run1    <= '0;
      run2    <= '0;
      ov_run  <= '0;
      sat_run <= '0;
    end else begin
      run1    <= phi1 ? run1 + 16'd1 : '0;
      run2    <= phi2 ? run2 + 16'd1 : '0;
      ov_run  <= phi_st ? ov_run + {15'd0, phi2} : '0;
      sat_run <= sat_gate ? sat_run + 16'd1 : '0;
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n) !(phi1 && phi2));
  p_phi1_width_r2: assert property (@(posedge clk) disable iff (!rst_n) $fell(phi1) |-> run1 >= 16'(MIN_HI));
  p_phi2_width_r2: assert property (@(posedge clk) disable iff (!rst_n) $fell(phi2) |-> run2 >= 16'(MIN_HI));
  p_st_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n) $fell(phi_st) |-> ov_run >= 16'(MIN_HI));
  p_st_with_phi2_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(phi_st) |-> phi2);
  p_phase_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n) (phi1 || phi2) |-> busy);
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(intv_end));
  p_clamp_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n) integ_clamped |=> integ_clamped);
  p_sat_width_r10: assert property (@(posedge clk) disable iff (!rst_n) $fell(sat_gate) |-> sat_run > 16'(ARST_MIN));
  p_sat_idle_r11: assert property (@(posedge clk) disable iff (!rst_n) sat_gate |-> !busy);

endmodule

bind lpa_scan_driver lpa_scan_checker #(.CLK_MHZ(CLK_MHZ), .MIN_HI(MIN_HI)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phi1          (phi1),
  .phi2          (phi2),
  .phi_st        (phi_st),
  .sat_gate      (sat_gate),
  .busy          (busy),
  .integ_clamped (integ_clamped),
  .intv_end      (intv_end)
);

// File: tb/lpa_scan_driver_test.sv
`timescale 1ns/1ps
module lpa_scan_driver_test;

  localparam int CLK_PERIOD = 20;
  localparam int ARST_EXP   = 251;

  typedef struct packed {
    logic [1:0]  code;
    logic [7:0]  hi;
    logic [7:0]  gp;
    logic [23:0] integ;
    logic [7:0]  exp_h;
    logic [10:0] exp_n;
    logic [23:0] exp_t;
    logic        exp_err;
  } vec_t;

  // Expected values were worked out from R2, R5, R6 and R7.
  localparam vec_t VECS [5] = '{
    '{2'd2, 8'd10, 8'd0, 24'd10240, 8'd10, 11'd512,  24'd10240, 1'b0},
    '{2'd0, 8'd12, 8'd3, 24'd5000,  8'd12, 11'd128,  24'd5000,  1'b0},
    '{2'd1, 8'd4,  8'd0, 24'd100,   8'd10, 11'd256,  24'd5120,  1'b1},
    '{2'd0, 8'd10, 8'd1, 24'd3000,  8'd10, 11'd128,  24'd3000,  1'b1},
    '{2'd3, 8'd10, 8'd2, 24'd0,     8'd10, 11'd1024, 24'd24576, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_pix_code = '0;
  logic [7:0]  cfg_high = '0;
  logic [7:0]  cfg_gap = '0;
  logic [23:0] cfg_integ = '0;
  logic        scan_req = 1'b0;
  logic        scan_cont = 1'b0;
  logic        arst_req = 1'b0;
  logic        phi1, phi2, phi_st, sat_gate, busy, integ_clamped;

  int total = 0;
  int fails = 0;

  int cyc = 0;
  int r1 = 0, r2 = 0, rs = 0, gr = 0;
  int h1min, h1max, h2min, h2max, stlen, gmin, gmax;
  int n2, stfalls, both, busy_cnt, sat_cnt, st_rises;
  int rise_t [4];
  logic p1 = 1'b0, p2 = 1'b0, pst = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpa_scan_driver uut (
    .clk(clk), .rst_n(rst_n), .cfg_pix_code(cfg_pix_code), .cfg_high(cfg_high),
    .cfg_gap(cfg_gap), .cfg_integ(cfg_integ), .scan_req(scan_req), .scan_cont(scan_cont),
    .arst_req(arst_req), .phi1(phi1), .phi2(phi2), .phi_st(phi_st), .sat_gate(sat_gate),
    .busy(busy), .integ_clamped(integ_clamped)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    h1min = 1 << 30; h1max = 0; h2min = 1 << 30; h2max = 0;
    gmin = 1 << 30; gmax = -1; stlen = 0;
    n2 = 0; stfalls = 0; both = 0; busy_cnt = 0; sat_cnt = 0; st_rises = 0;
    for (int k = 0; k < 4; k++) rise_t[k] = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #1 sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: samples at the falling edge, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (phi1 === 1'b1 && phi2 === 1'b1) both++;
    if (!phi1 && p1) begin
      if (r1 < h1min) h1min = r1;
      if (r1 > h1max) h1max = r1;
    end
    if (!phi2 && p2) begin
      if (r2 < h2min) h2min = r2;
      if (r2 > h2max) h2max = r2;
      if (phi_st) stfalls++;
    end
    if (!phi_st && pst) stlen = rs;
    if (phi1 && !p1) begin
      if (gr < gmin) gmin = gr;
      if (gr > gmax) gmax = gr;
    end
    if (phi2 && !p2) n2++;
    if (phi_st && !pst) begin
      if (st_rises < 4) rise_t[st_rises] = cyc;
      st_rises++;
    end
    r1 = phi1 ? r1 + 1 : 0;
    r2 = phi2 ? r2 + 1 : 0;
    rs = phi_st ? rs + 1 : 0;
    if (phi2) gr = 0; else if (!phi1) gr = gr + 1;
    if (busy) busy_cnt++;
    if (sat_gate) sat_cnt++;
    p1 = phi1; p2 = phi2; pst = phi_st;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R12 outputs in reset", {phi1, phi2, phi_st, sat_gate, busy, integ_clamped}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R12 outputs after reset", {phi1, phi2, phi_st, sat_gate, busy, integ_clamped}, 0);

    // Table walk: one single scan per entry, configuration scrambled mid-scan (R8).
    for (int i = 0; i < 5; i++) begin
      cfg_pix_code = VECS[i].code; cfg_high = VECS[i].hi;
      cfg_gap = VECS[i].gp; cfg_integ = VECS[i].integ;
      clear_stats();
      pulse(scan_req);
      repeat (40) @(posedge clk);
      #1 cfg_pix_code = 2'd3; cfg_high = 8'd200; cfg_gap = 8'd50; cfg_integ = 24'd1;
      wait_idle();
      chk($sformatf("R1 overlap cycles v%0d", i), both, 0);
      chk($sformatf("R2 phi1 min width v%0d", i), h1min, VECS[i].exp_h);
      chk($sformatf("R2 phi1 max width v%0d", i), h1max, VECS[i].exp_h);
      chk($sformatf("R2 phi2 min width v%0d", i), h2min, VECS[i].exp_h);
      chk($sformatf("R8 phi2 max width unchanged v%0d", i), h2max, VECS[i].exp_h);
      chk($sformatf("R3 gap min v%0d", i), gmin, VECS[i].gp);
      chk($sformatf("R3 gap max v%0d", i), gmax, VECS[i].gp);
      chk($sformatf("R5 phi2 pulses v%0d", i), n2, VECS[i].exp_n);
      chk($sformatf("R4 start width v%0d", i), stlen, VECS[i].exp_h + 1);
      chk($sformatf("R4 phi2 falls in start v%0d", i), stfalls, 1);
      chk($sformatf("R9 single start count v%0d", i), st_rises, 1);
      chk($sformatf("R6 busy length v%0d", i), busy_cnt, VECS[i].exp_t);
      chk($sformatf("R7 clamp flag v%0d", i), integ_clamped, VECS[i].exp_err);
    end

    // R9: continuous mode, T = max(3000, 128*20) = 3000.
    cfg_pix_code = 2'd0; cfg_high = 8'd10; cfg_gap = 8'd0; cfg_integ = 24'd3000;
    scan_cont = 1'b1;
    clear_stats();
    pulse(scan_req);
    while (st_rises < 2) @(negedge clk);
    repeat (100) @(posedge clk);
    #1 scan_cont = 1'b0;
    wait_idle();
    chk("R9 continuous start count", st_rises, 2);
    chk("R6 restart spacing", rise_t[1] - rise_t[0], 3000);
    chk("R9 continuous busy length", busy_cnt, 6000);
    chk("R5 continuous phi2 pulses", n2, 256);

    // R10: global clear pulse width.
    clear_stats();
    pulse(arst_req);
    repeat (10) @(posedge clk);
    chk("R10 gate high after request", sat_gate, 1);
    // R11: scan request during the clear pulse is ignored.
    pulse(scan_req);
    while (sat_gate) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R10 clear pulse length", sat_cnt, ARST_EXP);
    chk("R11 scan ignored during clear busy", busy_cnt, 0);
    chk("R11 scan ignored during clear phi2", n2, 0);

    // R11: clear request during a scan is ignored.
    clear_stats();
    pulse(scan_req);
    repeat (100) @(posedge clk);
    pulse(arst_req);
    wait_idle();
    chk("R11 clear ignored while busy", sat_cnt, 0);
    chk("R11 scan ran normally", n2, 128);

    // R11: simultaneous requests while idle, the scan wins.
    clear_stats();
    @(posedge clk); #1 scan_req = 1'b1; arst_req = 1'b1;
    @(posedge clk); #1 scan_req = 1'b0; arst_req = 1'b0;
    wait_idle();
    chk("R11 simultaneous requests no clear", sat_cnt, 0);
    chk("R11 simultaneous requests scan busy", busy_cnt, 3000);

    // R7: only reset clears the sticky flag.
    chk("R7 flag still set before reset", integ_clamped, 1);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R7 flag cleared by reset", integ_clamped, 0);
    chk("R12 outputs after second reset", {phi1, phi2, phi_st, sat_gate, busy}, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule